// File: doc/BRIEF.md
# Linked-List Transfer Descriptor Walker

This block is the fetch side of one DMA channel. Software sets a list pointer, a consumer cycle state and two enables through a 32-bit register port, then rings a doorbell. The walker reads descriptor elements one 32-bit word at a time through a request/response read port. It decodes each element's control word and turns every data element into a transfer command (source, destination, byte count and two interrupt-request flags) on a valid/ready output. Moving the data, converting bus protocols and arbitrating between channels are handled by other blocks.

Each element carries an ownership (cycle) bit. The walker consumes an element only if that bit matches its consumer cycle state. The first element that does not match ends the walk, and the pointer is left on that element. A link element redirects the pointer and can invert the consumer cycle state. This lets software reuse one ring of elements: it refills the ring with the opposite cycle value and rings the doorbell again.

Top module: `ll_desc_walker`

## Requirements
- R1: After reset the status field reads 0, the list pointer and the cycle-sync register read 0, and neither `mem_req` nor `cmd_valid` is asserted.
- R2: The register map (byte offsets) is: channel enable at 0x00 bit 0, doorbell at 0x04 bit 0, list pointer low word at 0x08 and high word at 0x0C, cycle-sync at 0x10, link-list enable at 0x14 bit 0, and a read-only 2-bit status at 0x18. Writing 1 to doorbell bit 0 while idle with both enables set starts fetching at the list pointer and sets status to 1 (running). If either enable is clear, status becomes 2 (error) and no read is issued.
- R3: An element's words are read from the pointer plus 4*k. The control word is word 0. Its bit 0 is the cycle bit, bit 1 toggle-cycle, bit 2 link, bit 3 local interrupt request and bit 4 remote interrupt request. A data element continues with size, source low, source high, destination low and destination high.
- R4: An element whose cycle bit differs from the consumer cycle state stops fetching. The pointer keeps that element's address. Status becomes 3 (complete) once the last command has been accepted.
- R5: A data element produces one command with src = {word3, word2}, dst = {word5, word4}, len = word1, and the local and remote flags from control bits 3 and 4. The command is held stable until `cmd_ready`.
- R6: After a data element is handed to the output, the pointer advances by 24 bytes. At most one command is pending, and a new one is not loaded before the previous one has been accepted.
- R7: A link element is three words: control, then next pointer low and high. The walk continues at {word2, word1}. When toggle-cycle is set, the consumer cycle state is inverted before the next fetch, and cycle-sync bit 1 is set.
- R8: A link element with toggle-cycle clear leaves the consumer cycle state unchanged.
- R9: While running, writes to the list pointer and cycle-sync registers and further doorbells have no effect.
- R10: A doorbell after a stop resumes at the element where the walk stopped, using the current consumer cycle state.
- R11: At most one memory read is outstanding. `mem_req` is not raised while a response is awaited.
- R12: Source and destination addresses are passed with every byte-address bit intact, including odd low bits and the high words.
- R13: A write to cycle-sync while idle loads bit 0 into the consumer cycle state and clears bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_src | output | 64 | Source byte address |
| cmd_dst | output | 64 | Destination byte address |
| cmd_len | output | 32 | Byte count |
| cmd_irq_local | output | 1 | Local interrupt request of the element |
| cmd_irq_remote | output | 1 | Remote interrupt request of the element |

## Verification
The in-RTL properties check the following on every clock: the start and refusal responses to a doorbell, the 24-byte pointer step on each hand-off, the pointer holding on an unowned element, cycle inversion on toggling links, the stability of a pending command, and the single-outstanding-read rule. Only the bench scenarios can show that whole chains come out as the right commands in the right order. The same applies to resuming at the stopped element after software refills a ring, and to writes made during a long run leaving the final pointer and cycle state untouched. A behavioural walker in the bench predicts the command stream from its memory image. Each accepted command is compared against that prediction, and so are the final register values.

// File: rtl/llw_pkg.sv
package llw_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFF_ENABLE   = 5'h00;
  localparam logic [REG_AW-1:0] OFF_DOORBELL = 5'h04;
  localparam logic [REG_AW-1:0] OFF_PTR_LO   = 5'h08;
  localparam logic [REG_AW-1:0] OFF_PTR_HI   = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_CYCSYNC  = 5'h10;
  localparam logic [REG_AW-1:0] OFF_LLCTRL   = 5'h14;
  localparam logic [REG_AW-1:0] OFF_STATUS   = 5'h18;

  // control word bit positions (decoded by the walker, written by software)
  localparam int CB_CYCLE   = 0;
  localparam int CB_TOGGLE  = 1;
  localparam int CB_LINK    = 2;
  localparam int CB_IRQ_LOC = 3;
  localparam int CB_IRQ_REM = 4;

  localparam int DATA_WORDS = 6;
  localparam int LINK_WORDS = 3;
  localparam int IDX_W      = $clog2(DATA_WORDS);
  localparam int DATA_BYTES = DATA_WORDS * (WORD_W / 8);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ERR  = 2'd2,
    ST_DONE = 2'd3
  } chan_status_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [WORD_W-1:0] len;
    logic              irq_loc;
    logic              irq_rem;
  } xfer_cmd_t;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + ADDR_W'({idx, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] after_data(input logic [ADDR_W-1:0] base);
    return base + ADDR_W'(DATA_BYTES);
  endfunction

  function automatic logic is_owned(input logic cycle_bit, input logic ccs);
    return cycle_bit == ccs;
  endfunction
endpackage

// File: rtl/llw_regs.sv
module llw_regs
  import llw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic                wbit0,
  output logic                chan_en,
  output logic                ll_en,
  output logic                db_pulse,
  output logic                ptr_lo_we,
  output logic                ptr_hi_we,
  output logic                cs_we,
  input  logic [ADDR_W-1:0]   ptr,
  input  logic                ccs,
  input  logic                cs_flag,
  input  logic [1:0]          status,
  output logic [WORD_W-1:0]   rdata
);
  assign db_pulse  = wr_en && (addr == OFF_DOORBELL) && wbit0;
  assign ptr_lo_we = wr_en && (addr == OFF_PTR_LO);
  assign ptr_hi_we = wr_en && (addr == OFF_PTR_HI);
  assign cs_we     = wr_en && (addr == OFF_CYCSYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= 1'b0;
      ll_en   <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFF_ENABLE) chan_en <= wbit0;
      if (addr == OFF_LLCTRL) ll_en   <= wbit0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_ENABLE:  rdata = {31'd0, chan_en};
      OFF_PTR_LO:  rdata = ptr[WORD_W-1:0];
      OFF_PTR_HI:  rdata = ptr[ADDR_W-1:WORD_W];
      OFF_CYCSYNC: rdata = {30'd0, cs_flag, ccs};
      OFF_LLCTRL:  rdata = {31'd0, ll_en};
      OFF_STATUS:  rdata = {30'd0, status};
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/llw_walker.sv
module llw_walker
  import llw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chan_en,
  input  logic                ll_en,
  input  logic                db_pulse,
  input  logic                ptr_lo_we,
  input  logic                ptr_hi_we,
  input  logic                cs_we,
  input  logic [WORD_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   ptr,
  output logic                ccs,
  output logic                cs_flag,
  output logic [1:0]          status,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic                mem_rvalid,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                ld_cmd,
  output xfer_cmd_t           ld_data,
  input  logic                stage_busy
);
  typedef enum logic [2:0] {W_IDLE, W_REQ, W_WAIT, W_CMD, W_DRAIN} wstate_e;

  wstate_e          state;
  chan_status_e     stat_q;
  logic [IDX_W-1:0] widx;
  logic [4:1]       ctrl_q;
  logic [WORD_W-1:0] len_q, src_lo, src_hi, dst_lo, dst_hi;

  // named events for the properties below
  logic             idle, start_fetch, start_refused, rsp;
  logic [4:1]       ctrl_flags;
  logic             not_owned, last_word, link_done, data_done, toggle_now, issue;
  logic [ADDR_W-1:0] link_target;

  assign idle          = (state == W_IDLE);
  assign start_fetch   = db_pulse && idle && chan_en && ll_en;
  assign start_refused = db_pulse && idle && !(chan_en && ll_en);
  assign rsp           = (state == W_WAIT) && mem_rvalid;
  assign ctrl_flags    = (widx == '0) ? mem_rdata[4:1] : ctrl_q;
  assign not_owned     = rsp && (widx == '0) && !is_owned(mem_rdata[CB_CYCLE], ccs);
  assign last_word     = rsp && !not_owned &&
                         (ctrl_flags[CB_LINK] ? (widx == IDX_W'(LINK_WORDS-1))
                                              : (widx == IDX_W'(DATA_WORDS-1)));
  assign link_done     = last_word && ctrl_flags[CB_LINK];
  assign data_done     = last_word && !ctrl_flags[CB_LINK];
  assign toggle_now    = link_done && ctrl_flags[CB_TOGGLE];
  assign issue         = (state == W_CMD) && !stage_busy;
  assign link_target   = {mem_rdata, len_q};

  assign mem_req  = (state == W_REQ);
  assign mem_addr = word_addr(ptr, widx);
  assign status   = stat_q;
  assign ld_cmd   = issue;
  assign ld_data  = '{src: {src_hi, src_lo}, dst: {dst_hi, dst_lo}, len: len_q,
                      irq_loc: ctrl_q[CB_IRQ_LOC], irq_rem: ctrl_q[CB_IRQ_REM]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= W_IDLE;
      stat_q  <= ST_IDLE;
      ptr     <= '0;
      ccs     <= 1'b0;
      cs_flag <= 1'b0;
      widx    <= '0;
      ctrl_q  <= '0;
      len_q   <= '0;
      src_lo  <= '0;
      src_hi  <= '0;
      dst_lo  <= '0;
      dst_hi  <= '0;
    end else begin
      if (rsp) begin
        unique case (widx)
          3'd0:    ctrl_q <= mem_rdata[4:1];
          3'd1:    len_q  <= mem_rdata;
          3'd2:    src_lo <= mem_rdata;
          3'd3:    src_hi <= mem_rdata;
          3'd4:    dst_lo <= mem_rdata;
          default: dst_hi <= mem_rdata;
        endcase
      end
      unique case (state)
        W_IDLE: begin
          if (ptr_lo_we) ptr[WORD_W-1:0] <= wdata;
          if (ptr_hi_we) ptr[ADDR_W-1:WORD_W] <= wdata;
          if (cs_we) begin
            ccs     <= wdata[0];
            cs_flag <= 1'b0;
          end
          if (start_fetch) begin
            state  <= W_REQ;
            widx   <= '0;
            stat_q <= ST_RUN;
          end else if (start_refused) begin
            stat_q <= ST_ERR;
          end
        end
        W_REQ: if (mem_ack) state <= W_WAIT;
        W_WAIT: begin
          if (rsp) begin
            if (not_owned) begin
              state <= W_DRAIN;
            end else if (link_done) begin
              ptr   <= link_target;
              widx  <= '0;
              state <= W_REQ;
              if (toggle_now) begin
                ccs     <= !ccs;
                cs_flag <= 1'b1;
              end
            end else if (data_done) begin
              state <= W_CMD;
            end else begin
              widx  <= widx + 1'b1;
              state <= W_REQ;
            end
          end
        end
        W_CMD: begin
          if (issue) begin
            ptr   <= after_data(ptr);
            widx  <= '0;
            state <= W_REQ;
          end
        end
        W_DRAIN: begin
          if (!stage_busy) begin
            stat_q <= ST_DONE;
            state  <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // outstanding-read tracker kept apart from the FSM for R11
  logic [1:0] rd_outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_outst <= '0;
    else rd_outst <= rd_outst + {1'b0, mem_req && mem_ack} - {1'b0, mem_rvalid};
  end

  assert_one_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> rd_outst == 2'd0);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_fetch |=> (status == 2'd1) && mem_req);
  assert_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_refused |=> (status == 2'd2) && !mem_req);
  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ptr == $past(ptr) + 64'd24);
  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    not_owned |=> (ptr == $past(ptr)) && !mem_req);
  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_now |=> (ccs != $past(ccs)) && cs_flag);
  assert_ignore_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cs_we && !toggle_now) |=> ccs == $past(ccs));
endmodule

// File: rtl/llw_cmd_stage.sv
module llw_cmd_stage
  import llw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  xfer_cmd_t  ld_data,
  output logic       busy,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output xfer_cmd_t  cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else if (ld) begin
      cmd_valid <= 1'b1;
      cmd       <= ld_data;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
  assign busy = cmd_valid;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd));
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !cmd_valid);
endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker
  import llw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic                mem_rvalid,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [ADDR_W-1:0]   cmd_src,
  output logic [ADDR_W-1:0]   cmd_dst,
  output logic [WORD_W-1:0]   cmd_len,
  output logic                cmd_irq_local,
  output logic                cmd_irq_remote
);
  logic chan_en, ll_en, db_pulse, ptr_lo_we, ptr_hi_we, cs_we;
  logic [ADDR_W-1:0] ptr;
  logic ccs, cs_flag, ld_cmd, stage_busy;
  logic [1:0] status;
  xfer_cmd_t ld_data, cmd;

  llw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wbit0(reg_wdata[0]),
    .chan_en(chan_en), .ll_en(ll_en), .db_pulse(db_pulse), .ptr_lo_we(ptr_lo_we),
    .ptr_hi_we(ptr_hi_we), .cs_we(cs_we), .ptr(ptr), .ccs(ccs), .cs_flag(cs_flag),
    .status(status), .rdata(reg_rdata)
  );

  llw_walker u_walk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ll_en(ll_en), .db_pulse(db_pulse),
    .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we), .cs_we(cs_we), .wdata(reg_wdata),
    .ptr(ptr), .ccs(ccs), .cs_flag(cs_flag), .status(status),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_cmd(ld_cmd), .ld_data(ld_data), .stage_busy(stage_busy)
  );

  llw_cmd_stage u_out (
    .clk(clk), .rst_n(rst_n), .ld(ld_cmd), .ld_data(ld_data), .busy(stage_busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd(cmd)
  );

  assign cmd_src        = cmd.src;
  assign cmd_dst        = cmd.dst;
  assign cmd_len        = cmd.len;
  assign cmd_irq_local  = cmd.irq_loc;
  assign cmd_irq_remote = cmd.irq_rem;
endmodule

// File: tb/ll_desc_walker_test.sv
module ll_desc_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [63:0] cmd_src, cmd_dst;
  logic [31:0] cmd_len;
  logic cmd_irq_local, cmd_irq_remote;

  ll_desc_walker uut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [63:0] s; logic [63:0] d; logic [31:0] n; logic il; logic ir;
  } xfer_t;

  int n_chk = 0, n_bad = 0, cyc = 0, lat = 1, rdy_mode = 0, n_acks = 0;
  logic [31:0] mem [0:1023];
  xfer_t exp_q [$];
  logic [63:0] m_ptr = '0;
  logic m_ccs = 1'b0, m_flag = 1'b0, m_en = 1'b0, m_llen = 1'b0;
  logic [1:0] m_status = 2'd0;
  bit busy = 0;
  int rsp_cnt = 0;
  logic [9:0] raddr = '0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      finish_all();
    end
  end

  // memory model, output sink and per-cycle comparison
  always @(negedge clk) begin
    logic rdy;
    xfer_t e;
    mem_rvalid = 1'b0;
    mem_ack = 1'b0;
    if (mem_req && busy) begin
      n_chk++; n_bad++;
      $display("FAIL R11 request while read outstanding: actual=1 expected=0");
    end
    if (busy) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem[raddr];
        busy = 0;
      end
    end else if (mem_req) begin
      mem_ack = 1'b1;
      raddr = mem_addr[11:2];
      busy = 1;
      rsp_cnt = lat;
      n_acks++;
    end
    rdy = (rdy_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    cmd_ready = rdy;
    if (cmd_valid && rdy) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R5 unexpected command: actual src=%h expected none", cmd_src);
      end else begin
        e = exp_q.pop_front();
        check("R5/R12", "cmd_src", cmd_src, e.s);
        check("R5/R12", "cmd_dst", cmd_dst, e.d);
        check("R5", "cmd_len+irq", {30'd0, cmd_len, cmd_irq_local, cmd_irq_remote}, {30'd0, e.n, e.il, e.ir});
      end
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ptr(input logic [63:0] p);
    reg_write(5'h08, p[31:0]); reg_write(5'h0C, p[63:32]);
    m_ptr = p;
  endtask

  task automatic set_ccs(input logic v);
    reg_write(5'h10, {31'd0, v});
    m_ccs = v; m_flag = 1'b0;
  endtask

  task automatic set_en(input logic ce, input logic le);
    reg_write(5'h00, {31'd0, ce}); reg_write(5'h14, {31'd0, le});
    m_en = ce; m_llen = le;
  endtask

  task automatic put_data(input int a, input logic [31:0] c, input logic [31:0] n,
                          input logic [63:0] s, input logic [63:0] d);
    mem[a/4] = c; mem[a/4+1] = n; mem[a/4+2] = s[31:0]; mem[a/4+3] = s[63:32];
    mem[a/4+4] = d[31:0]; mem[a/4+5] = d[63:32];
  endtask

  task automatic put_link(input int a, input logic [31:0] c, input logic [63:0] nx);
    mem[a/4] = c; mem[a/4+1] = nx[31:0]; mem[a/4+2] = nx[63:32];
  endtask

  // behavioural walk over the bench memory image
  task automatic model_walk();
    if (!(m_en && m_llen)) begin
      m_status = 2'd2;
      return;
    end
    for (int k = 0; k < 64; k++) begin
      int w;
      logic [31:0] c;
      w = int'(m_ptr[11:2]);
      c = mem[w];
      if (c[0] != m_ccs) break;
      if (c[2]) begin
        if (c[1]) begin m_ccs = !m_ccs; m_flag = 1'b1; end
        m_ptr = {mem[w+2], mem[w+1]};
      end else begin
        exp_q.push_back('{s: {mem[w+3], mem[w+2]}, d: {mem[w+5], mem[w+4]},
                          n: mem[w+1], il: c[3], ir: c[4]});
        m_ptr = m_ptr + 64'd24;
      end
    end
    m_status = 2'd3;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int k = 0; k < 5000; k++) begin
      reg_read(5'h18, r);
      if (r[1:0] != 2'd1) break;
    end
  endtask

  task automatic end_state(input string req);
    logic [31:0] r;
    wait_idle();
    reg_read(5'h18, r); check(req, "status", {62'd0, r[1:0]}, {62'd0, m_status});
    reg_read(5'h08, r); check(req, "ptr_lo", {32'd0, r}, {32'd0, m_ptr[31:0]});
    reg_read(5'h0C, r); check(req, "ptr_hi", {32'd0, r}, {32'd0, m_ptr[63:32]});
    reg_read(5'h10, r); check(req, "cycsync", {32'd0, r}, {62'd0, m_flag, m_ccs});
    check(req, "commands left", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic run(input string req);
    model_walk();
    reg_write(5'h04, 32'd1);
    end_state(req);
  endtask

  initial begin
    logic [31:0] r;
    int acks0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_read(5'h18, r); check("R1", "status", {32'd0, r}, 64'd0);
    reg_read(5'h08, r); check("R1", "ptr_lo", {32'd0, r}, 64'd0);
    reg_read(5'h10, r); check("R1", "cycsync", {32'd0, r}, 64'd0);
    check("R1", "mem_req", {63'd0, mem_req}, 64'd0);
    check("R1", "cmd_valid", {63'd0, cmd_valid}, 64'd0);

    // R2: refused doorbells, no fetch
    acks0 = n_acks;
    run("R2 none enabled");
    set_en(1'b1, 1'b0);
    run("R2 ll disabled");
    repeat (4) @(negedge clk);
    check("R2", "reads while refused", 64'(n_acks - acks0), 64'd0);

    // R3 R5 R6 R12 R4: three data elements then an unowned one
    set_en(1'b1, 1'b1);
    set_ptr(64'h100);
    set_ccs(1'b1);
    put_data(32'h100, 32'h1, 32'h40, 64'h0000_0001_2345_6789, 64'h0000_0002_0000_0003);
    put_data(32'h118, 32'h1, 32'h1000, 64'hDEAD_0000_0000_0005, 64'h0000_00FF_FFFF_FFFE);
    put_data(32'h130, 32'h19, 32'h7, 64'h11, 64'h22);
    mem[32'h148/4] = 32'h0;
    run("R4 first chain");

    // R10 R7: resume with backpressure and slow memory, toggling link
    rdy_mode = 1; lat = 3;
    put_data(32'h148, 32'h1, 32'h9, 64'h33, 64'h44);
    put_link(32'h160, 32'h7, 64'h200);
    put_data(32'h200, 32'h0, 32'h55, 64'h0123_4567_89AB_CDEF, 64'h5);
    put_data(32'h218, 32'h8, 32'h66, 64'h6, 64'h7);
    mem[32'h230/4] = 32'h1;
    run("R10 R7 resume+toggle");

    // R8: link without toggle keeps the cycle state
    put_link(32'h230, 32'h4, 64'h300);
    put_data(32'h300, 32'h10, 32'h77, 64'h8, 64'h9);
    mem[32'h318/4] = 32'h1;
    run("R8 plain link");

    // R9: writes during a run are ignored; R13 idle cycle-sync load
    lat = 6; rdy_mode = 0;
    set_ptr(64'h400);
    set_ccs(1'b0);
    reg_read(5'h10, r); check("R13", "cycsync after load", {32'd0, r}, 64'd0);
    put_data(32'h400, 32'h0, 32'hA, 64'hA0, 64'hB0);
    put_data(32'h418, 32'h0, 32'hB, 64'hA1, 64'hB1);
    mem[32'h430/4] = 32'h1;
    model_walk();
    reg_write(5'h04, 32'd1);
    reg_write(5'h08, 32'h800);
    reg_write(5'h10, 32'h1);
    reg_write(5'h04, 32'd1);
    end_state("R9 writes while running");

    // R7 R10: ring reuse by refill with opposite cycle value
    lat = 2; rdy_mode = 1;
    set_ptr(64'h500);
    put_data(32'h500, 32'h0, 32'hC, 64'hC0, 64'hD0);
    put_link(32'h518, 32'h6, 64'h500);
    run("R7 ring pass one");
    put_data(32'h500, 32'h9, 32'hE, 64'hE0, 64'hF0);
    put_link(32'h518, 32'h7, 64'h500);
    run("R10 ring pass two");

    // R2: error after clearing link-list enable
    set_en(1'b1, 1'b0);
    run("R2 late refuse");

    repeat (5) @(negedge clk);
    finish_all();
  end
endmodule